// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 values of the same precision, either 32-bit or 64-bit, and reduces the comparison to a single condition bit. It works out whether the first operand is below the second, whether they are equal, or whether they cannot be ordered because one of them is a NaN. A 4-bit predicate picks which of these relations make the condition true. A further bit of the predicate asks for an invalid-operation flag when the operands are unordered, even if the NaNs are quiet. An optional magnitude mode ignores both signs.

The unit is fed one operation per strobe. The 32-bit form takes its operands from the low half of each 64-bit input. One cycle after the strobe, the unit returns three things with a matching valid pulse: the condition bit, the index of the condition-code slot (one of eight) that it targets, and the invalid status bit. The control-register logic that keeps the condition codes and status flags is outside the block.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, out_valid, out_result and out_invalid are 0 and out_cc_idx is 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 otherwise. While in_valid is low the result, index and invalid outputs keep their last values.
- R3: With fmt_dbl = 0, each operand is the 32-bit value in bits 31:0 (sign at bit 31, exponent at bits 30:23, fraction at bits 22:0). Bits 63:32 have no effect.
- R4: With fmt_dbl = 1, each operand is the full 64-bit value (sign at bit 63, exponent at bits 62:52, fraction at bits 51:0).
- R5: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN, the pair is unordered and both less and equal are false.
- R6: out_invalid is 1 only for an unordered pair. It is set when cond[3] is 1, or when either NaN is signalling (fraction MSB clear). Quiet NaNs with cond[3] = 0 leave it at 0.
- R7: With abs_mode = 1, ordered operands are compared by magnitude, with both signs treated as positive.
- R8: Less is strict: it is true only when the first operand is numerically below the second and not equal to it.
- R9: out_result = (cond[2] & less) | (cond[1] & equal) | (cond[0] & unordered).
- R10: +0 and -0 compare equal. Infinities are ordered values: -inf is below every finite value and +inf is above every finite value.
- R11: out_cc_idx returns the cc_idx that was presented with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| fmt_dbl | input | 1 | 1 = 64-bit format, 0 = 32-bit format in the low half |
| abs_mode | input | 1 | Compare magnitudes only |
| cond | input | 4 | Predicate: bit 2 less, bit 1 equal, bit 0 unordered, bit 3 invalid on any NaN |
| cc_idx | input | 3 | Target condition-code slot |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 1 | Condition bit |
| out_cc_idx | output | 3 | Slot the condition bit goes to |
| out_invalid | output | 1 | Invalid-operation status |

## Verification
Each of less, equal and unordered is tested on its own with a one-hot predicate, and then with predicates that combine them. A combined predicate shows whether the relations are ORed correctly or whether one of them leaks into the others. Operand pairs cover signs that agree and signs that differ (these separate magnitude order from numeric order), opposite zeros and infinities, and junk in the upper half under the 32-bit format. Quiet and signalling NaNs are paired with cond[3] set and clear, which separates the signalling rule from the requested-invalid rule. The same magnitude-mode pairs run with the mode off and on, and the 64-bit cases show that the format select moves the fields.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    parameter int unsigned WORD_W     = 64;
    parameter int unsigned SGL_EXP_W  = 8;
    parameter int unsigned SGL_FRAC_W = 23;
    parameter int unsigned DBL_EXP_W  = 11;
    parameter int unsigned DBL_FRAC_W = 52;
    parameter int unsigned CC_W       = 3;
    parameter int unsigned PRED_W     = 4;
    localparam int unsigned MAG_W     = WORD_W - 1;

    // predicate bit positions
    localparam int unsigned P_UN  = 0;
    localparam int unsigned P_EQ  = 1;
    localparam int unsigned P_LT  = 2;
    localparam int unsigned P_SIG = 3;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_zero;
        logic             is_nan;
        logic             is_snan;
    } opnd_t;

    typedef struct packed {
        logic            valid;
        logic            result;
        logic [CC_W-1:0] cc;
        logic            invalid;
    } cmp_state_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic              fmt_dbl,
    output opnd_t             info
);
    localparam int unsigned S_TOP = SGL_EXP_W + SGL_FRAC_W;
    localparam int unsigned D_TOP = DBL_EXP_W + DBL_FRAC_W;

    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    always_comb begin
        info = '0;
        if (fmt_dbl) begin
            info.sign = op[D_TOP];
            info.mag  = MAG_W'(op[D_TOP-1:0]);
            exp_ones  = &op[D_TOP-1:DBL_FRAC_W];
            frac_nz   = |op[DBL_FRAC_W-1:0];
            quiet_bit = op[DBL_FRAC_W-1];
        end else begin
            info.sign = op[S_TOP];
            info.mag  = MAG_W'(op[S_TOP-1:0]);
            exp_ones  = &op[S_TOP-1:SGL_FRAC_W];
            frac_nz   = |op[SGL_FRAC_W-1:0];
            quiet_bit = op[SGL_FRAC_W-1];
        end
        info.is_zero = (info.mag == '0);
        info.is_nan  = exp_ones & frac_nz;
        info.is_snan = info.is_nan & ~quiet_bit;
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    input  logic  abs_mode,
    output logic  lt,
    output logic  eq,
    output logic  unord
);
    logic sa, sb;
    logic mag_lt, mag_eq;

    always_comb begin
        unord  = a.is_nan | b.is_nan;
        sa     = a.sign & ~abs_mode;
        sb     = b.sign & ~abs_mode;
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        lt     = 1'b0;
        eq     = 1'b0;
        if (!unord) begin
            if (a.is_zero && b.is_zero) begin
                eq = 1'b1;
            end else if (sa != sb) begin
                lt = sa;
            end else begin
                eq = mag_eq;
                lt = sa ? (~mag_lt & ~mag_eq) : mag_lt;
            end
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              fmt_dbl,
    input  logic              abs_mode,
    input  logic [PRED_W-1:0] cond,
    input  logic [CC_W-1:0]   cc_idx,
    output logic              out_valid,
    output logic              out_result,
    output logic [CC_W-1:0]   out_cc_idx,
    output logic              out_invalid
);
    localparam int unsigned N_OPS = 2;

    logic [WORD_W-1:0] ops [N_OPS];
    opnd_t             info [N_OPS];
    logic              rel_lt, rel_eq, rel_un;
    cmp_state_t        st_d, st_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fpcmp_classify u_cls (
            .op      (ops[g]),
            .fmt_dbl (fmt_dbl),
            .info    (info[g])
        );
    end

    fpcmp_order u_ord (
        .a        (info[0]),
        .b        (info[1]),
        .abs_mode (abs_mode),
        .lt       (rel_lt),
        .eq       (rel_eq),
        .unord    (rel_un)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = (cond[P_LT] & rel_lt) | (cond[P_EQ] & rel_eq)
                         | (cond[P_UN] & rel_un);
            st_d.cc      = cc_idx;
            st_d.invalid = rel_un & (cond[P_SIG] | info[0].is_snan | info[1].is_snan);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_cc_idx  = st_q.cc;
    assign out_invalid = st_q.invalid;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_invalid)); // R2
    AST_CC_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_cc_idx == $past(cc_idx)); // R11
    AST_ORDERED_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rel_un) |=> !out_invalid); // R6
    AST_NAN_IS_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (info[0].is_nan || info[1].is_nan)) |-> (rel_un && !rel_lt && !rel_eq)); // R5
    AST_LT_EXCLUDES_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !(rel_lt && rel_eq)); // R8
endmodule

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        fmt_dbl = 1'b0, abs_mode = 1'b0;
    logic [3:0]  cond = '0;
    logic [2:0]  cc_idx = '0;
    logic        out_valid, out_result, out_invalid;
    logic [2:0]  out_cc_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fpcmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .fmt_dbl(fmt_dbl), .abs_mode(abs_mode), .cond(cond), .cc_idx(cc_idx),
        .out_valid(out_valid), .out_result(out_result), .out_cc_idx(out_cc_idx),
        .out_invalid(out_invalid)
    );

    localparam logic [3:0] C_LT = 4'b0100, C_EQ = 4'b0010, C_UN = 4'b0001;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmp(input string req, input logic dbl, input logic [63:0] a,
                       input logic [63:0] b, input logic ab, input logic [3:0] c,
                       input logic [2:0] cc, input logic exp_res, input logic exp_inv);
        @(negedge clk);
        op_a = a; op_b = b; fmt_dbl = dbl; abs_mode = ab; cond = c; cc_idx = cc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid R2"}, 8'(out_valid), 8'd1);
        check({req, " result"}, 8'(out_result), 8'(exp_res));
        check({req, " invalid"}, 8'(out_invalid), 8'(exp_inv));
        check({req, " cc R11"}, 8'(out_cc_idx), 8'(cc));
    endtask

    // 32-bit encodings
    localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000, SM1 = 64'hBF800000,
        SM2 = 64'hC0000000, SPZ = 64'h0, SNZ = 64'h80000000, SPI = 64'h7F800000,
        SNI = 64'hFF800000, SQN = 64'h7FC00000, SSN = 64'h7F800001;
    // 64-bit encodings
    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000,
        DM2 = 64'hC000000000000000, DQN = 64'h7FF8000000000000,
        DSN = 64'h7FF0000000000001, DPI = 64'h7FF0000000000000;

    task automatic t_reset();
        check("R1 valid", 8'(out_valid), 8'd0);
        check("R1 result", 8'(out_result), 8'd0);
        check("R1 invalid", 8'(out_invalid), 8'd0);
        check("R1 cc", 8'(out_cc_idx), 8'd0);
    endtask

    task automatic t_single_order();
        cmp("R8 1<2", 0, S1, S2, 0, C_LT, 3'd1, 1, 0);
        cmp("R8 2<1", 0, S2, S1, 0, C_LT, 3'd2, 0, 0);
        cmp("R8 1<1 strict", 0, S1, S1, 0, C_LT, 3'd3, 0, 0);
        cmp("R8 1==1", 0, S1, S1, 0, C_EQ, 3'd4, 1, 0);
        cmp("R8 -1<1", 0, SM1, S1, 0, C_LT, 3'd5, 1, 0);
        cmp("R8 -2<-1", 0, SM2, SM1, 0, C_LT, 3'd6, 1, 0);
        cmp("R8 -1<-2", 0, SM1, SM2, 0, C_LT, 3'd7, 0, 0);
    endtask

    task automatic t_upper_ignored();
        cmp("R3 junk high eq", 0, {32'hDEADBEEF, 32'h3F800000}, S1, 0, C_EQ, 3'd0, 1, 0);
        cmp("R3 junk high lt", 0, {32'hFFF80000, 32'h3F800000}, S2, 0, C_LT, 3'd1, 1, 0);
    endtask

    task automatic t_zero_inf();
        cmp("R10 +0==-0", 0, SPZ, SNZ, 0, C_EQ, 3'd2, 1, 0);
        cmp("R10 -0<+0", 0, SNZ, SPZ, 0, C_LT, 3'd3, 0, 0);
        cmp("R10 -inf<-2", 0, SNI, SM2, 0, C_LT, 3'd4, 1, 0);
        cmp("R10 2<+inf", 0, S2, SPI, 0, C_LT, 3'd5, 1, 0);
        cmp("R10 inf==inf", 0, SPI, SPI, 0, C_UN | C_EQ, 3'd6, 1, 0);
    endtask

    task automatic t_abs();
        cmp("R7 -2<1 plain", 0, SM2, S1, 0, C_LT, 3'd1, 1, 0);
        cmp("R7 |-2|<|1|", 0, SM2, S1, 1, C_LT, 3'd1, 0, 0);
        cmp("R7 |-1|==|1|", 0, SM1, S1, 1, C_EQ, 3'd2, 1, 0);
        cmp("R7 |1|<|-2|", 0, S1, SM2, 1, C_LT, 3'd3, 1, 0);
    endtask

    task automatic t_nan();
        cmp("R5 qnan un", 0, SQN, S1, 0, C_UN, 3'd0, 1, 0);
        cmp("R5 qnan lt|eq", 0, S1, SQN, 0, C_LT | C_EQ, 3'd1, 0, 0);
        cmp("R5 qnan self eq", 0, SQN, SQN, 0, C_EQ, 3'd2, 0, 0);
        cmp("R6 qnan sig req", 0, SQN, S1, 0, 4'b1000, 3'd3, 0, 1);
        cmp("R6 snan", 0, S1, SSN, 0, C_UN, 3'd4, 1, 1);
        cmp("R6 ordered sig req", 0, S1, S2, 0, 4'b1100, 3'd5, 1, 0);
        cmp("R6 abs qnan", 0, SQN, SM1, 1, C_EQ, 3'd6, 0, 0);
    endtask

    task automatic t_combine();
        cmp("R9 lt via 0111", 0, S1, S2, 0, 4'b0111, 3'd7, 1, 0);
        cmp("R9 lt miss 0011", 0, S1, S2, 0, 4'b0011, 3'd0, 0, 0);
        cmp("R9 eq via 0110", 0, S2, S2, 0, 4'b0110, 3'd1, 1, 0);
        cmp("R9 gt 0111", 0, S2, S1, 0, 4'b0111, 3'd2, 0, 0);
        cmp("R9 un via 0101", 0, SQN, S2, 0, 4'b0101, 3'd3, 1, 0);
    endtask

    task automatic t_double();
        cmp("R4 1<2", 1, D1, D2, 0, C_LT, 3'd4, 1, 0);
        cmp("R4 -2<1", 1, DM2, D1, 0, C_LT, 3'd5, 1, 0);
        cmp("R4 |-2|==2", 1, DM2, D2, 1, C_EQ, 3'd6, 1, 0);
        cmp("R4 low-half value", 1, S1, SPZ, 0, C_EQ, 3'd7, 0, 0);
        cmp("R4 qnan", 1, DQN, D1, 0, C_UN, 3'd0, 1, 0);
        cmp("R4 snan", 1, D1, DSN, 0, C_UN, 3'd1, 1, 1);
        cmp("R4 2<inf", 1, D2, DPI, 0, C_LT, 3'd2, 1, 0);
        cmp("R4 32-bit nan pattern not nan", 1, SQN, D1, 0, C_UN, 3'd3, 0, 0);
    endtask

    task automatic t_hold();
        cmp("R2 setup", 0, S1, S2, 0, C_LT, 3'd5, 1, 0);
        @(negedge clk);
        op_a = S2; op_b = S1; cond = C_LT; cc_idx = 3'd2;
        @(negedge clk);
        check("R2 idle valid", 8'(out_valid), 8'd0);
        check("R2 idle result", 8'(out_result), 8'd1);
        check("R2 idle cc", 8'(out_cc_idx), 8'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_order();
        t_upper_ignored();
        t_zero_inf();
        t_abs();
        t_nan();
        t_combine();
        t_double();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule